// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block drives the repeat loop of a 16-bit processor's string instructions. The block takes a start command that carries five things: the kind of element operation (move, compare, scan, load or store), the element size (byte or word), a repeat mode, the starting count and the two pointer values. It also samples the direction flag and the current zero flag.

After a start, the block hands one element at a time to an external datapath through a request/acknowledge handshake. For each element it presents the source and destination pointers. When the element is acknowledged, the block steps the pointers that the operation kind uses. With a repeat mode active, it also decrements the count. It then decides whether to run another element. Compare and scan elements return a fresh zero flag with the acknowledge. In the two conditional repeat modes, that flag can end the loop before the count runs out.

When sequencing ends, the block raises a one-cycle completion pulse. The final count, pointers and zero flag stay on the outputs until the next start. Memory access, segment selection and interruption of a running loop are handled outside this block.

Top module: `strrep_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `step_req_o` are 0 and `cx_o`, `si_o`, `di_o` are 0. A start is taken only when neither `busy_o` nor `done_o` is high. A start raised while a loop is running has no effect on that loop or on its results.
- R2: With `rep_i` not 0 and `cx_i` equal to 0, no element is requested. `done_o` is high in the cycle after the start. The count, pointers and zero flag keep their start values.
- R3: With `rep_i` = 0 (no repeat), exactly one element is requested and the count is left unchanged.
- R4: With `rep_i` = 1 (unconditional), elements are requested until the count reaches 0. Each acknowledged element lowers the count by 1, so N elements are run for a start count of N.
- R5: With `rep_i` = 2 (while equal) and kind compare (1) or scan (2), the loop ends after the first element whose returned `step_zf_i` is 0, or when the count reaches 0, whichever comes first.
- R6: With `rep_i` = 3 (while not equal) and kind compare or scan, the loop ends after the first element whose returned `step_zf_i` is 1, or when the count reaches 0.
- R7: For kinds move (0), load (3) and store (4), `step_zf_i` is ignored. Under modes 2 and 3 such loops run until the count reaches 0, and `zf_o` keeps the value sampled from `zf_i` at the start.
- R8: After each acknowledged element, every pointer in use moves by 1 when `word_i` = 0 or by 2 when `word_i` = 1. It moves upward when `df_i` = 0 and downward when `df_i` = 1. All arithmetic wraps modulo 2^16.
- R9: Move and compare step both pointers. Scan and store step only `di_o`. Load steps only `si_o`. A pointer that is not in use keeps its start value.
- R10: `step_req_o` is high only while `busy_o` is high. `step_src_o` and `step_dst_o` equal the current pointer values, and they hold steady until `step_ack_i` is seen. Each cycle with both `step_req_o` and `step_ack_i` high completes exactly one element.
- R11: `done_o` is a single-cycle pulse. It rises in the cycle after the final acknowledge. At that point `cx_o`, `si_o`, `di_o` and `zf_o` show the final values, and they hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command |
| kind_i | input | 3 | Operation kind: 0 move, 1 compare, 2 scan, 3 load, 4 store |
| word_i | input | 1 | Element size: 0 byte, 1 word |
| rep_i | input | 2 | Repeat mode: 0 none, 1 unconditional, 2 while equal, 3 while not equal |
| df_i | input | 1 | Direction flag: 0 up, 1 down |
| zf_i | input | 1 | Zero flag at start |
| cx_i | input | 16 | Start count |
| si_i | input | 16 | Start source pointer |
| di_i | input | 16 | Start destination pointer |
| step_req_o | output | 1 | Element request to datapath |
| step_ack_i | input | 1 | Element completed by datapath |
| step_zf_i | input | 1 | Zero flag from a compare or scan element, valid with acknowledge |
| step_kind_o | output | 3 | Kind of the requested element |
| step_word_o | output | 1 | Size of the requested element |
| step_src_o | output | 16 | Source pointer of the requested element |
| step_dst_o | output | 16 | Destination pointer of the requested element |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cx_o | output | 16 | Current or final count |
| si_o | output | 16 | Current or final source pointer |
| di_o | output | 16 | Current or final destination pointer |
| zf_o | output | 1 | Current or final zero flag |

## Verification
The bound checker watches several rules on every cycle:
- the request stays within the busy window, and its pointers hold through a stall;
- each acknowledge lowers the count by one or leaves it alone, depending on the repeat mode;
- each pointer steps by the size and direction latched at start, or stays put when its kind does not use it;
- a zero-count start skips straight to completion, and completion is a single pulse.

Only the bench's scenarios show loop-level behaviour:
- how many elements a conditional mode runs before a returned zero flag stops it;
- that a non-comparing kind runs through a zero flag that would have stopped a compare;
- that a start raised mid-loop leaves the final results untouched.

// File: rtl/strrep_pkg.sv
package strrep_pkg;

  typedef enum logic [2:0] {
    SK_MOVE  = 3'd0,
    SK_CMP   = 3'd1,
    SK_SCAN  = 3'd2,
    SK_LOAD  = 3'd3,
    SK_STORE = 3'd4
  } skind_e;

  typedef enum logic [1:0] {
    RP_NONE = 2'd0,
    RP_ALL  = 2'd1,
    RP_EQ   = 2'd2,
    RP_NE   = 2'd3
  } rep_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FIN  = 2'd2
  } seq_e;

  // kinds that read through the source pointer
  function automatic logic kind_uses_src(skind_e k);
    return (k == SK_MOVE) || (k == SK_CMP) || (k == SK_LOAD);
  endfunction

  // kinds that touch the destination pointer
  function automatic logic kind_uses_dst(skind_e k);
    return (k == SK_MOVE) || (k == SK_CMP) || (k == SK_SCAN) || (k == SK_STORE);
  endfunction

  // kinds whose element produces a zero flag
  function automatic logic kind_sets_zf(skind_e k);
    return (k == SK_CMP) || (k == SK_SCAN);
  endfunction

endpackage

// File: rtl/strrep_rstsync.sv
module strrep_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/strrep_ptr.sv
module strrep_ptr #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur_i,
  input  logic          en_i,
  input  logic          dec_i,
  input  logic          word_i,
  output logic [AW-1:0] nxt_o
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  logic [AW-1:0] delta;

  always_comb begin
    delta = word_i ? STEP_W : STEP_B;
    if (!en_i)      nxt_o = cur_i;
    else if (dec_i) nxt_o = cur_i - delta;
    else            nxt_o = cur_i + delta;
  end
endmodule

// File: rtl/strrep_stop.sv
module strrep_stop
  import strrep_pkg::*;
#(
  parameter int CW = 16
) (
  input  rep_e          rep_start_i,
  input  logic [CW-1:0] cx_start_i,
  input  rep_e          rep_i,
  input  logic          zf_valid_i,
  input  logic [CW-1:0] cx_nxt_i,
  input  logic          zf_nxt_i,
  output logic          skip_o,
  output logic          stop_o
);
  logic cnt_out;
  logic zf_out;

  always_comb begin
    skip_o  = (rep_start_i != RP_NONE) && (cx_start_i == '0);
    cnt_out = (cx_nxt_i == '0);
    zf_out  = 1'b0;
    if (zf_valid_i) begin
      if (rep_i == RP_EQ) zf_out = !zf_nxt_i;
      if (rep_i == RP_NE) zf_out = zf_nxt_i;
    end
    stop_o = (rep_i == RP_NONE) || cnt_out || zf_out;
  end
endmodule

// File: rtl/strrep_seq.sv
module strrep_seq
  import strrep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic skip_i,
  input  logic fire_i,
  input  logic stop_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o
);
  seq_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          state_d  = skip_i ? SQ_FIN : SQ_RUN;
        end
      end
      SQ_RUN:  if (fire_i && stop_i) state_d = SQ_FIN;
      SQ_FIN:  state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o = (state_q == SQ_RUN);
  assign done_o = (state_q == SQ_FIN);
endmodule

// File: rtl/strrep_ctrl.sv
module strrep_ctrl
  import strrep_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    kind_i,
  input  logic          word_i,
  input  logic [1:0]    rep_i,
  input  logic          df_i,
  input  logic          zf_i,
  input  logic [CW-1:0] cx_i,
  input  logic [AW-1:0] si_i,
  input  logic [AW-1:0] di_i,
  output logic          step_req_o,
  input  logic          step_ack_i,
  input  logic          step_zf_i,
  output logic [2:0]    step_kind_o,
  output logic          step_word_o,
  output logic [AW-1:0] step_src_o,
  output logic [AW-1:0] step_dst_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] cx_o,
  output logic [AW-1:0] si_o,
  output logic [AW-1:0] di_o,
  output logic          zf_o
);
  localparam int NLANE = 2;

  logic rst_n_s;
  logic accept, fire, skip, stop;

  skind_e kind_q;
  rep_e   rep_q;
  logic   word_q, dec_q, zf_q;
  logic [CW-1:0] cx_q, cx_nxt;
  logic          zf_nxt;

  logic [NLANE-1:0][AW-1:0] ptr_q, ptr_nxt, ptr_ld;
  logic [NLANE-1:0]         lane_en;

  strrep_rstsync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  assign fire = step_req_o && step_ack_i;

  // control fields captured at start
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      kind_q <= SK_MOVE;
      rep_q  <= RP_NONE;
      word_q <= 1'b0;
      dec_q  <= 1'b0;
    end else if (accept) begin
      kind_q <= skind_e'(kind_i);
      rep_q  <= rep_e'(rep_i);
      word_q <= word_i;
      dec_q  <= df_i;
    end
  end

  // count and zero flag next values
  always_comb begin
    cx_nxt = (rep_q != RP_NONE) ? cx_q - CW'(1) : cx_q;
    zf_nxt = kind_sets_zf(kind_q) ? step_zf_i : zf_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cx_q <= '0;
      zf_q <= 1'b0;
    end else if (accept) begin
      cx_q <= cx_i;
      zf_q <= zf_i;
    end else if (fire) begin
      cx_q <= cx_nxt;
      zf_q <= zf_nxt;
    end
  end

  // pointer lanes: 0 = source, 1 = destination
  assign lane_en = {kind_uses_dst(kind_q), kind_uses_src(kind_q)};
  assign ptr_ld  = {di_i, si_i};

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    strrep_ptr #(.AW(AW)) u_ptr (
      .cur_i (ptr_q[g]),
      .en_i  (lane_en[g]),
      .dec_i (dec_q),
      .word_i(word_q),
      .nxt_o (ptr_nxt[g])
    );

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s)    ptr_q[g] <= '0;
      else if (accept) ptr_q[g] <= ptr_ld[g];
      else if (fire)   ptr_q[g] <= ptr_nxt[g];
    end
  end

  strrep_stop #(.CW(CW)) u_stop (
    .rep_start_i(rep_e'(rep_i)),
    .cx_start_i (cx_i),
    .rep_i      (rep_q),
    .zf_valid_i (kind_sets_zf(kind_q)),
    .cx_nxt_i   (cx_nxt),
    .zf_nxt_i   (zf_nxt),
    .skip_o     (skip),
    .stop_o     (stop)
  );

  strrep_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start_i (start_i),
    .skip_i  (skip),
    .fire_i  (fire),
    .stop_i  (stop),
    .accept_o(accept),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assign step_req_o  = busy_o;
  assign step_kind_o = kind_q;
  assign step_word_o = word_q;
  assign step_src_o  = ptr_q[0];
  assign step_dst_o  = ptr_q[1];
  assign cx_o        = cx_q;
  assign si_o        = ptr_q[0];
  assign di_o        = ptr_q[1];
  assign zf_o        = zf_q;
endmodule

// File: rtl/strrep_chk.sv
module strrep_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [2:0]    kind_i,
  input logic          word_i,
  input logic [1:0]    rep_i,
  input logic          df_i,
  input logic [CW-1:0] cx_i,
  input logic          step_req_o,
  input logic          step_ack_i,
  input logic [AW-1:0] step_src_o,
  input logic [AW-1:0] step_dst_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] cx_o,
  input logic [AW-1:0] si_o,
  input logic [AW-1:0] di_o
);
  logic          acc;
  logic          fire;
  logic [1:0]    rep_c;
  logic          word_c, df_c, src_c, dst_c;
  logic [AW-1:0] dlt;

  assign acc  = start_i && !busy_o && !done_o;
  assign fire = step_req_o && step_ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_c <= '0; word_c <= 1'b0; df_c <= 1'b0; src_c <= 1'b0; dst_c <= 1'b0;
    end else if (acc) begin
      rep_c  <= rep_i;
      word_c <= word_i;
      df_c   <= df_i;
      src_c  <= (kind_i == 3'd0) || (kind_i == 3'd1) || (kind_i == 3'd3);
      dst_c  <= (kind_i == 3'd0) || (kind_i == 3'd1) || (kind_i == 3'd2) || (kind_i == 3'd4);
    end
  end

  assign dlt = df_c ? (word_c ? -AW'(2) : -AW'(1)) : (word_c ? AW'(2) : AW'(1));

  assert_req_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    step_req_o |-> busy_o);
  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    step_req_o && !step_ack_i |=> step_req_o && $stable(step_src_o) && $stable(step_dst_o));
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);
  assert_zero_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (rep_i != 2'd0) && (cx_i == '0) |=> done_o && !step_req_o);
  assert_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (rep_c == 2'd0) |=> $stable(cx_o) && done_o);
  assert_count_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (rep_c != 2'd0) |=> cx_o == $past(cx_o) - CW'(1));
  assert_src_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && src_c |=> si_o == $past(si_o) + $past(dlt));
  assert_dst_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && dst_c |=> di_o == $past(di_o) + $past(dlt));
  assert_src_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !src_c |=> $stable(si_o));
  assert_dst_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !dst_c |=> $stable(di_o));
endmodule

bind strrep_ctrl strrep_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .kind_i    (kind_i),
  .word_i    (word_i),
  .rep_i     (rep_i),
  .df_i      (df_i),
  .cx_i      (cx_i),
  .step_req_o(step_req_o),
  .step_ack_i(step_ack_i),
  .step_src_o(step_src_o),
  .step_dst_o(step_dst_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .cx_o      (cx_o),
  .si_o      (si_o),
  .di_o      (di_o)
);

// File: tb/sim_strrep_ctrl.sv
module sim_strrep_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  kind_i;
  logic        word_i;
  logic [1:0]  rep_i;
  logic        df_i, zf_i;
  logic [15:0] cx_i, si_i, di_i;
  logic        step_req_o, step_ack_i, step_zf_i;
  logic [2:0]  step_kind_o;
  logic        step_word_o;
  logic [15:0] step_src_o, step_dst_o;
  logic        busy_o, done_o;
  logic [15:0] cx_o, si_o, di_o;
  logic        zf_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  strrep_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i), .word_i(word_i),
    .rep_i(rep_i), .df_i(df_i), .zf_i(zf_i), .cx_i(cx_i), .si_i(si_i), .di_i(di_i),
    .step_req_o(step_req_o), .step_ack_i(step_ack_i), .step_zf_i(step_zf_i),
    .step_kind_o(step_kind_o), .step_word_o(step_word_o),
    .step_src_o(step_src_o), .step_dst_o(step_dst_o),
    .busy_o(busy_o), .done_o(done_o), .cx_o(cx_o), .si_o(si_o), .di_o(di_o), .zf_o(zf_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected below 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one start, serviced by a datapath model; results compared with a requirement model
  task automatic run_op(input string req, input int kind, input bit word, input int rep,
                        input int cx, input int si, input int di, input bit df, input bit zf0,
                        input int stop_idx, input bit stall, input bit poke);
    int  e_n = 0, e_cx = cx, e_si = si, e_di = di;
    bit  e_zf = zf0;
    int  dl = word ? 2 : 1;
    bit  stopv = (rep == 3);
    bit  cond = (kind == 1) || (kind == 2);
    bit  usrc = (kind == 0) || (kind == 1) || (kind == 3);
    bit  udst = (kind != 3);
    int  n = 0;
    bit  phase = 0;
    bit  first = 1;
    // requirement model
    if (!(rep != 0 && cx == 0)) begin
      for (int i = 0; i < 70000; i++) begin
        bit r;
        e_n++;
        if (usrc) e_si = (df ? e_si - dl : e_si + dl) & 16'hffff;
        if (udst) e_di = (df ? e_di - dl : e_di + dl) & 16'hffff;
        if (rep != 0) e_cx = (e_cx - 1) & 16'hffff;
        r = (i == stop_idx) ? stopv : !stopv;
        if (cond) e_zf = r;
        if (rep == 0 || e_cx == 0) break;
        if (cond && ((rep == 2 && !e_zf) || (rep == 3 && e_zf))) break;
      end
    end
    @(negedge clk);
    kind_i = 3'(kind); word_i = word; rep_i = 2'(rep); df_i = df; zf_i = zf0;
    cx_i = 16'(cx); si_i = 16'(si); di_i = 16'(di); start_i = 1'b1;
    forever begin
      @(negedge clk);
      step_ack_i = 1'b0; start_i = 1'b0;
      if (done_o) break;
      if (step_req_o) begin
        if (first) begin
          chk("R10", "first source pointer", int'(step_src_o), si);
          first = 0;
        end
        if (stall && !phase) phase = 1;
        else begin
          phase = 0;
          step_ack_i = 1'b1;
          step_zf_i = (n == stop_idx) ? stopv : !stopv;
          n++;
          if (poke && n == 1) begin
            start_i = 1'b1; cx_i = 16'd99; si_i = 16'h5555; di_i = 16'h6666;
          end
        end
      end
    end
    chk(req, "elements", n, e_n);
    chk(req, "final count", int'(cx_o), e_cx);
    chk(req, "final source", int'(si_o), e_si);
    chk(req, "final destination", int'(di_o), e_di);
    chk(req, "final zero flag", int'(zf_o), int'(e_zf));
    @(negedge clk);
    chk("R11", "done is one cycle", int'(done_o), 0);
    chk("R11", "results held", int'(cx_o), e_cx);
  endtask

  task automatic t_reset();
    chk("R1", "busy after reset", int'(busy_o), 0);
    chk("R1", "done after reset", int'(done_o), 0);
    chk("R1", "request after reset", int'(step_req_o), 0);
    chk("R1", "count after reset", int'(cx_o), 0);
    chk("R1", "pointers after reset", int'(si_o) + int'(di_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; kind_i = '0; word_i = 1'b0; rep_i = '0;
    df_i = 1'b0; zf_i = 1'b0; cx_i = '0; si_i = '0; di_i = '0;
    step_ack_i = 1'b0; step_zf_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    // kind, word, rep, cx, si, di, df, zf0, stop_idx, stall, poke
    run_op("R3", 0, 0, 0, 5, 16'h0100, 16'h0200, 0, 0, 999, 0, 0);
    run_op("R4", 0, 1, 1, 4, 16'h1000, 16'h2000, 0, 0, 999, 1, 0);
    run_op("R8", 4, 0, 1, 3, 16'h0300, 16'h0010, 1, 0, 999, 0, 0);
    run_op("R9", 3, 1, 1, 2, 16'h0040, 16'h0500, 1, 1, 999, 0, 0);
    run_op("R8", 0, 1, 1, 2, 16'hFFFF, 16'h0001, 0, 0, 999, 0, 0);
    run_op("R2", 2, 0, 1, 0, 16'h0700, 16'h0800, 0, 1, 999, 0, 0);
    run_op("R5", 1, 0, 2, 10, 16'h0000, 16'h0100, 0, 1, 3, 1, 0);
    run_op("R6", 2, 1, 3, 6, 16'h0000, 16'h0400, 1, 0, 1, 0, 0);
    run_op("R5", 1, 1, 2, 3, 16'h0020, 16'h0030, 0, 0, 999, 0, 0);
    run_op("R6", 1, 0, 3, 1, 16'h0020, 16'h0030, 0, 0, 0, 0, 0);
    run_op("R7", 0, 0, 2, 3, 16'h0900, 16'h0A00, 0, 1, 0, 0, 0);
    run_op("R7", 4, 1, 3, 2, 16'h0900, 16'h0A00, 0, 0, 0, 0, 0);
    run_op("R1", 0, 0, 1, 5, 16'h0111, 16'h0222, 0, 0, 999, 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule